// File: doc/BRIEF.md
# Programmable Interval Timer with Prescaler

A 16-bit down-counting periodic timer on a small 16-bit register bus. Software programs a control/status word, a modulus value, and reads the live count back. The count steps down once per prescaled tick. Each tick is half the clock rate divided by a power of two that software chooses. When the count expires, a sticky flag is raised, and a level interrupt line follows that flag while interrupts are enabled.

Two expiry policies exist. In reload mode the count restarts from the programmed modulus. In free-run mode it wraps to all ones. An overwrite option makes a modulus write load the count at once, so a period can be shortened without waiting for the old one to finish. Control writes that only touch the interrupt enable, or only clear the flag, leave the running count and the prescaler phase undisturbed. Any other control change restarts the prescaler.

Top module: `itmr_top`

## Requirements
- R1: After reset the control word reads 0x0000, the modulus reads 0xFFFF, the count reads 0xFFFF and `irq` is 0.
- R2: Registers sit at bus offset 0 (control/status), 2 (modulus) and 4 (count). Any other offset reads 0. Writes to offset 4, or to any other offset, change nothing.
- R3: The control word uses these bits: 0 enable, 1 reload, 2 flag, 3 interrupt enable, 4 overwrite, 5 debug, 6 doze, and 11:8 prescale PRE. While enabled, the count takes one step every 2^(PRE+1) clocks, counted from the last prescaler restart.
- R4: On each tick the count drops by one. A tick that finds the count at 0 is an expiry: it sets the flag and loads the limit instead.
- R5: The limit is the modulus when reload=1, and 0xFFFF when reload=0.
- R6: Writing control with bit 2 set clears the flag. Writing it with bit 2 clear leaves the flag as it was. An expiry on the same edge wins and leaves the flag set.
- R7: `irq` is 1 exactly when the flag and the interrupt enable are both 1.
- R8: Any write to the modulus clears the flag, unless an expiry happens on the same edge.
- R9: A modulus write with overwrite=1 loads the count with the written value at once and restarts the prescaler. With overwrite=0 the count is untouched, and the new value is used at the next expiry when reload=1.
- R10: A control write whose stored bits differ only in the interrupt enable (apart from the flag) keeps the prescaler phase. Any other difference restarts the prescaler, and the count keeps its value.
- R11: While enable=0 the count holds its value.
- R12: Debug and doze are stored and read back, but have no effect on timing. Bits 7 and 15:12 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for the addressed register |
| addr | input | 3 | Byte offset of the register |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the addressed register (combinational) |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its default widths: a 16-bit count and a 4-bit prescale field. It sets the modulus to small values through the overwrite path, so several expiries in reload mode and a free-run wrap to 0xFFFF happen within a few hundred cycles. The prescale values 0, 1, 3 and 15 cover the shortest tick, restarts in the middle of a tick, and a tick too long to occur during the test. A behavioural model tracks every register and the interrupt line cycle by cycle. It covers writes that only touch the interrupt enable, writes to the flag, writes to the modulus with and without overwrite, and writes to a read-only or unused offset.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
  localparam int DATA_W = 16;
  localparam int PRE_W  = 4;
  localparam int ADDR_W = 3;

  localparam int B_EN     = 0;
  localparam int B_RLD    = 1;
  localparam int B_FLAG   = 2;
  localparam int B_IE     = 3;
  localparam int B_OVW    = 4;
  localparam int B_DBG    = 5;
  localparam int B_DOZE   = 6;
  localparam int B_PRE_LO = 8;

  localparam int OFF_CTRL = 0;
  localparam int OFF_MOD  = 2;
  localparam int OFF_CNT  = 4;

  typedef struct packed {
    logic modWr;
    logic cntLoad;
    logic preRestart;
  } dpCmd_t;
endpackage

// File: rtl/itmr_ctrl.sv
module itmr_ctrl
  import itmr_pkg::*;
#(
  parameter int DATA_W = itmr_pkg::DATA_W,
  parameter int PRE_W  = itmr_pkg::PRE_W,
  parameter int ADDR_W = itmr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              expire,
  output dpCmd_t            cmd,
  output logic [DATA_W-1:0] ctrlQ,
  output logic              flagQ,
  output logic              irq
);
  localparam logic [DATA_W-1:0] PRE_MASK   = DATA_W'(((1 << PRE_W) - 1) << B_PRE_LO);
  localparam logic [DATA_W-1:0] FLAG_BITS  = DATA_W'((1 << B_EN) | (1 << B_RLD) | (1 << B_IE) |
                                                     (1 << B_OVW) | (1 << B_DBG) | (1 << B_DOZE));
  localparam logic [DATA_W-1:0] STORE_MASK = PRE_MASK | FLAG_BITS;
  localparam logic [DATA_W-1:0] CFG_MASK   = STORE_MASK & ~DATA_W'(1 << B_IE);

  logic ctrlWr, modWr, cfgChanged, flagClr;

  assign ctrlWr     = wrEn && (addr == ADDR_W'(OFF_CTRL));
  assign modWr      = wrEn && (addr == ADDR_W'(OFF_MOD));
  assign cfgChanged = |((ctrlQ ^ wrData) & CFG_MASK);
  assign flagClr    = (ctrlWr && wrData[B_FLAG]) || modWr;

  always_comb begin
    cmd.modWr      = modWr;
    cmd.cntLoad    = modWr && ctrlQ[B_OVW];
    cmd.preRestart = ctrlWr && cfgChanged;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
      flagQ <= 1'b0;
    end else begin
      if (ctrlWr) ctrlQ <= wrData & STORE_MASK;
      if (expire)       flagQ <= 1'b1;
      else if (flagClr) flagQ <= 1'b0;
    end
  end

  assign irq = flagQ && ctrlQ[B_IE];

  // R6: write-one-to-clear on the flag bit
  a_r6_flag_w1c: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && wrData[B_FLAG] && !expire |=> !flagQ);
  // R6: the flag stays set unless something clears it
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    flagQ && !flagClr |=> flagQ);
  // R8: a modulus write clears the flag
  a_r8_mod_clears: assert property (@(posedge clk) disable iff (!rstN)
    modWr && !expire |=> !flagQ);
  // R4: an expiry from the datapath sets the flag
  a_r4_expire_sets: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> flagQ);
endmodule

// File: rtl/itmr_datapath.sv
module itmr_datapath
  import itmr_pkg::*;
#(
  parameter int DATA_W = itmr_pkg::DATA_W,
  parameter int PRE_W  = itmr_pkg::PRE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] wrData,
  input  logic              en,
  input  logic              rld,
  input  logic [PRE_W-1:0]  pre,
  output logic [DATA_W-1:0] modQ,
  output logic [DATA_W-1:0] cntQ,
  output logic              expire
);
  localparam int PRE_CNT_W = 1 << PRE_W;

  logic [PRE_CNT_W-1:0] preCnt, preTerm;
  logic [DATA_W-1:0]    limit;
  logic                 preHit, tick, preClr;

  assign preTerm = (PRE_CNT_W'(1) << ({1'b0, pre} + (PRE_W+1)'(1))) - PRE_CNT_W'(1);
  assign preHit  = (preCnt == preTerm);
  assign preClr  = !en || cmd.preRestart || cmd.cntLoad;
  assign tick    = !preClr && preHit;
  assign expire  = tick && (cntQ == '0);
  assign limit   = rld ? modQ : '1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
      modQ   <= '1;
      cntQ   <= '1;
    end else begin
      if (preClr || preHit) preCnt <= '0;
      else                  preCnt <= preCnt + PRE_CNT_W'(1);
      if (cmd.modWr) modQ <= wrData;
      if (cmd.cntLoad)   cntQ <= wrData;
      else if (expire)   cntQ <= limit;
      else if (tick)     cntQ <= cntQ - DATA_W'(1);
    end
  end

  // R5: reload mode takes the modulus on expiry
  a_r5_reload: assert property (@(posedge clk) disable iff (!rstN)
    expire && rld && !cmd.modWr |=> cntQ == modQ);
  // R5: free-run mode wraps to all ones
  a_r5_freerun: assert property (@(posedge clk) disable iff (!rstN)
    expire && !rld |=> cntQ == '1);
  // R11: a disabled counter holds
  a_r11_hold: assert property (@(posedge clk) disable iff (!rstN)
    !en && !cmd.cntLoad |=> $stable(cntQ));
  // R9: overwrite loads the written value
  a_r9_load: assert property (@(posedge clk) disable iff (!rstN)
    cmd.cntLoad |=> cntQ == $past(wrData));
endmodule

// File: rtl/itmr_top.sv
module itmr_top
  import itmr_pkg::*;
#(
  parameter int DATA_W = itmr_pkg::DATA_W,
  parameter int PRE_W  = itmr_pkg::PRE_W,
  parameter int ADDR_W = itmr_pkg::ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              irq
);
  dpCmd_t            cmd;
  logic [DATA_W-1:0] ctrlQ, modQ, cntQ;
  logic              flagQ, expire;

  itmr_ctrl #(.DATA_W(DATA_W), .PRE_W(PRE_W), .ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .expire(expire), .cmd(cmd), .ctrlQ(ctrlQ), .flagQ(flagQ), .irq(irq)
  );

  itmr_datapath #(.DATA_W(DATA_W), .PRE_W(PRE_W)) uDp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .wrData(wrData),
    .en(ctrlQ[B_EN]), .rld(ctrlQ[B_RLD]), .pre(ctrlQ[B_PRE_LO +: PRE_W]),
    .modQ(modQ), .cntQ(cntQ), .expire(expire)
  );

  always_comb begin
    case (addr)
      ADDR_W'(OFF_CTRL): rdData = ctrlQ | (DATA_W'(flagQ) << B_FLAG);
      ADDR_W'(OFF_MOD):  rdData = modQ;
      ADDR_W'(OFF_CNT):  rdData = cntQ;
      default:           rdData = '0;
    endcase
  end
endmodule

// File: tb/tb_itmr_top.sv
module tb_itmr_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  addr = 3'd4;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;

  int    nChecks = 0;
  int    nFails = 0;
  bit    done = 0;
  string curReq = "R1";

  itmr_top dut (.clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
                .wrData(wrData), .rdData(rdData), .irq(irq));

  always #5 clk = ~clk;

  // behavioural reference state
  logic [15:0] mCtrl, mMod, mCnt;
  bit          mFlag;
  int          mElapsed;

  always @(posedge clk) begin
    bit cw, mw, rs, ld, tk, ex;
    int period;
    if (!rstN) begin
      mCtrl = 0; mFlag = 0; mMod = 16'hFFFF; mCnt = 16'hFFFF; mElapsed = 0;
    end else begin
      cw = wrEn && addr == 0;
      mw = wrEn && addr == 2;
      rs = cw && (((mCtrl ^ wrData) & 16'h0F73) != 0);
      ld = mw && mCtrl[4];
      period = 2 ** (int'(mCtrl[11:8]) + 1);
      tk = mCtrl[0] && !rs && !ld && (mElapsed + 1 == period);
      ex = tk && mCnt == 0;
      if (!mCtrl[0] || rs || ld || tk) mElapsed = 0;
      else mElapsed = mElapsed + 1;
      if (ld) mCnt = wrData;
      else if (ex) mCnt = mCtrl[1] ? mMod : 16'hFFFF;
      else if (tk) mCnt = mCnt - 1;
      if (ex) mFlag = 1;
      else if ((cw && wrData[2]) || mw) mFlag = 0;
      if (mw) mMod = wrData;
      if (cw) mCtrl = wrData & 16'h0F7B;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    int expRd;
    if (rstN && !done) begin
      case (addr)
        3'd0: expRd = int'(mCtrl | (16'(mFlag) << 2));
        3'd2: expRd = int'(mMod);
        3'd4: expRd = int'(mCnt);
        default: expRd = 0;
      endcase
      chk({curReq, " read"}, int'(rdData), expRd);
      chk("R7 irq", int'(irq), int'(mFlag && mCtrl[3]));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #2;
    wrEn = 1; addr = a; wrData = d;
    @(posedge clk); #2;
    wrEn = 0; addr = 3'd4;
  endtask

  task automatic peek(input logic [2:0] a, input string req, input int exp);
    @(posedge clk); #2;
    addr = a;
    @(negedge clk);
    chk(req, int'(rdData), exp);
    @(posedge clk); #2;
    addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic finishUp();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishUp();
  end

  initial begin
    int a0, a1;
    idle(3);
    #2 rstN = 1;
    // R1 reset values
    peek(0, "R1 ctrl", 0);
    peek(2, "R1 mod", 16'hFFFF);
    peek(4, "R1 cnt", 16'hFFFF);
    chk("R1 irq", int'(irq), 0);

    // R12 storage-only bits, unused bits read zero
    curReq = "R12";
    wr(0, 16'hF0E0);
    peek(0, "R12 dbg/doze readback", 16'h0060);
    idle(10);
    peek(4, "R12 count unaffected", 16'hFFFF);

    // R2 read-only and unused offsets
    curReq = "R2";
    wr(4, 16'h1234);
    peek(4, "R2 count write ignored", 16'hFFFF);
    wr(6, 16'h5555);
    peek(6, "R2 unused offset", 0);
    peek(2, "R2 mod untouched", 16'hFFFF);

    // R9 overwrite load while stopped
    curReq = "R9";
    wr(0, 16'h0010);
    wr(2, 16'h0005);
    peek(4, "R9 overwrite load", 5);

    // R3 R4 R5 free-run, PRE=0
    curReq = "R3/R4/R5";
    wr(0, 16'h0019);
    idle(20);
    peek(0, "R4 flag set on expiry", 16'h001D);
    chk("R7 irq high", int'(irq), 1);

    // R6 flag write semantics, R10 IE-only writes keep phase
    curReq = "R6/R10";
    wr(0, 16'h0019);
    peek(0, "R6 write zero keeps flag", 16'h001D);
    wr(0, 16'h001D);
    peek(0, "R6 write one clears", 16'h0019);
    wr(0, 16'h0011);
    peek(0, "R10 IE-only write", 16'h0011);
    chk("R7 irq low", int'(irq), 0);
    idle(7);

    // R5 reload mode, PRE=1
    curReq = "R5/R9";
    wr(0, 16'h011B);
    wr(2, 16'h0003);
    idle(60);
    peek(0, "R5 reload expiries set flag", 16'h011F);

    // R8 modulus write clears flag; R9 ovw=0 keeps count
    curReq = "R8/R9";
    wr(0, 16'h010B);
    wr(2, 16'h0002);
    peek(0, "R8 mod write clears flag", 16'h010B);
    idle(80);

    // R10 restart mid-tick, PRE=3
    curReq = "R10";
    wr(0, 16'h030B);
    idle(21);
    wr(0, 16'h032B);
    idle(50);
    wr(0, 16'h0327);
    idle(45);

    // R11 disabled count holds
    curReq = "R11";
    wr(0, 16'h0000);
    @(negedge clk); a0 = int'(rdData);
    idle(12);
    @(negedge clk); a1 = int'(rdData);
    chk("R11 count held", a1, a0);

    // R3 longest prescale: no tick within the window
    curReq = "R3";
    wr(0, 16'h0F01);
    @(negedge clk); a0 = int'(rdData);
    idle(100);
    @(negedge clk); a1 = int'(rdData);
    chk("R3 PRE=15 no early tick", a1, a0);
    idle(3);
    finishUp();
  end
endmodule